// File: doc/BRIEF.md
# Speculative Lock Elision Controller

This block sequences speculative lock elision for an instruction pipeline. A classifier in front of it sends acquire and release events. Each event carries the lock address, the lock data value and the pointer of the instruction. The controller counts how deeply elided locks are nested. It keeps an active flag. It saves the restart pointer from the outermost acquire. It holds a small buffer of elided lock address and value pairs.

When the outermost release completes with every buffer entry freed, the controller asks the commit logic to make the transaction permanent. It waits on a done/ok handshake. Any violation raises a one-cycle abort. An abort clears all elision state and pulses a discard request for the register and memory checkpoints. It also presents the saved restart pointer so that the pipeline can redirect. Register checkpointing itself sits outside this block. It is represented only by a start pulse and a discard pulse. Events are expected one per cycle; acquire and release are not both valid in the same cycle.

Top module: `elision_ctrl`

## Requirements
- R1: An acquire while the nest level is below MAX_NEST raises the nest level by one. An acquire at level 0 sets `active`, latches `cur_ip` into `restart_ip` and pulses `tx_start` for one cycle. Later acquires leave `restart_ip` unchanged. The nest level never exceeds MAX_NEST.
- R2: An acquire while the nest level equals MAX_NEST aborts.
- R3: An acquire takes the lowest-numbered free buffer entry. Bit i of `buf_valid` shows that entry i is occupied. With no entry free, the acquire still nests but allocates nothing.
- R4: A release at a nonzero nest level lowers the level by one. If its address matches an occupied entry and its data equals the recorded data, the lowest such matching entry is freed.
- R5: A release whose address matches an occupied entry with different recorded data aborts.
- R6: A release while the nest level is 0 changes no output.
- R7: When a release brings the level to 0 with no entry left occupied, `commit_req` rises the next cycle and stays high until `commit_done`. When `commit_done` arrives with `commit_ok` high, `active` and `commit_req` clear without an abort.
- R8: When `commit_done` arrives with `commit_ok` low, the controller aborts.
- R9: When a release brings the level to 0 while any entry is still occupied, the controller aborts.
- R10: An abort shows as a one-cycle pulse on `abort` and `discard`, one cycle after its cause. In that cycle `active`, the nest level, `buf_valid` and `commit_req` are all zero, and `restart_ip` still holds the outermost acquire pointer.
- R11: `ext_abort` while `active` aborts. While inactive it has no effect.
- R12: While a commit is pending, acquire and release events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_vld | input | 1 | Acquire event strobe |
| rel_vld | input | 1 | Release event strobe |
| lock_addr | input | AW | Lock address of the event |
| lock_data | input | DW | Lock data value of the event |
| cur_ip | input | IPW | Pointer of the event's instruction |
| ext_abort | input | 1 | Conflict or capacity abort request |
| commit_done | input | 1 | Commit attempt finished |
| commit_ok | input | 1 | Commit attempt succeeded (valid with done) |
| commit_req | output | 1 | Commit request, held until done |
| active | output | 1 | Elided execution in progress |
| nest_level | output | $clog2(MAX_NEST+1) | Current nesting depth |
| tx_start | output | 1 | Pulse: begin checkpoint and tracking |
| abort | output | 1 | Pulse: abort, redirect to restart_ip |
| discard | output | 1 | Pulse: discard checkpointed state |
| restart_ip | output | IPW | Saved outermost acquire pointer |
| buf_valid | output | DEPTH | Per-entry occupancy of the elision buffer |

## Verification
A single acquire and release pair with equal data is run against two kinds of nesting. The first uses distinct addresses that overflow the buffer, which separates the nest counter from buffer occupancy. The second runs to the nesting ceiling, which shows whether the limit check uses the right bound. Release variants cover a mismatched value, an unmatched address that leaves an entry behind at the outermost level, and a release with nothing nested; each one isolates a single abort or no-op path. Commit success is set against commit failure. External aborts are sent both while active and while idle, and events arrive while a commit is still pending.

// File: rtl/elide_pkg.sv
// Package: shared helpers for the lock elision controller.
// Assumes: parameters given to the helpers are positive.
package elide_pkg;
    // Width needed to hold an index into n entries (at least 1 bit).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width needed to count from 0 to n inclusive.
    function automatic int cnt_w(input int n);
        return (n > 0) ? $clog2(n + 1) : 1;
    endfunction
endpackage

// File: rtl/elide_nest_cnt.sv
// Module: nesting counter for elided locks.
// Counts up on inc and down on dec, and clears on clr (clr wins).
// Assumes the caller never raises inc at the maximum or dec at zero.
module elide_nest_cnt #(
    parameter int MAX_NEST = 7,
    parameter int CW       = elide_pkg::cnt_w(MAX_NEST)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          clr,
    output logic [CW-1:0] level,
    output logic          at_max,
    output logic          is_zero,
    output logic          is_one
);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_NEST);

    logic [CW-1:0] cnt_q;

    // Purpose: hold the nesting depth.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       cnt_q <= '0;
        else if (inc && !dec)    cnt_q <= cnt_q + 1'b1;
        else if (dec && !inc)    cnt_q <= cnt_q - 1'b1;
    end

    // Purpose: decode the counter state for the sequencer.
    always_comb begin
        level   = cnt_q;
        at_max  = (cnt_q == LIMIT);
        is_zero = (cnt_q == '0);
        is_one  = (cnt_q == CW'(1));
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);
endmodule

// File: rtl/elide_buffer.sv
// Module: small associative buffer of elided lock address/data pairs.
// Allocation takes the lowest free entry. A release lookup finds the
// lowest occupied entry whose address matches and compares its data.
// Assumes alloc is raised only when free_avail is high, and that clr
// takes priority over alloc and rel_free.
module elide_buffer #(
    parameter int DEPTH = 2,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             alloc,
    input  logic             rel_free,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    data,
    output logic             free_avail,
    output logic             hit,
    output logic             val_ok,
    output logic             left_after,
    output logic [DEPTH-1:0] valid_o
);
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] match_v;
    logic [DEPTH-1:0] data_eq;
    logic [DEPTH-1:0] alloc_oh;
    logic [DEPTH-1:0] rel_oh;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Purpose: compare the event against entry g.
        always_comb begin
            match_v[g] = vld_q[g] && (addr_q[g] == addr);
            data_eq[g] = (data_q[g] == data);
        end

        // Purpose: store, keep or free entry g.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                vld_q[g]  <= 1'b0;
                addr_q[g] <= '0;
                data_q[g] <= '0;
            end else if (alloc && alloc_oh[g]) begin
                vld_q[g]  <= 1'b1;
                addr_q[g] <= addr;
                data_q[g] <= data;
            end else if (rel_free && rel_oh[g]) begin
                vld_q[g]  <= 1'b0;
            end
        end
    end

    // Purpose: pick the lowest free entry for allocation.
    always_comb begin
        logic found;
        found    = 1'b0;
        alloc_oh = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!vld_q[i] && !found) begin
                alloc_oh[i] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    // Purpose: pick the lowest matching entry for a release.
    always_comb begin
        logic found;
        found  = 1'b0;
        rel_oh = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match_v[i] && !found) begin
                rel_oh[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    // Purpose: summarize the lookup for the sequencer.
    always_comb begin
        free_avail = ~&vld_q;
        hit        = |match_v;
        val_ok     = |(rel_oh & data_eq);
        left_after = |(vld_q & ~((hit && val_ok) ? rel_oh : '0));
        valid_o    = vld_q;
    end

    // R3
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !clr) |-> free_avail);

    // R3
    alloc_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !clr) |=> ($countones(vld_q) == $countones($past(vld_q)) + 1));
endmodule

// File: rtl/elision_ctrl.sv
// Module: top of the speculative lock elision controller.
// It decides each cycle between nesting, releasing, committing and
// aborting, and drives the counter and the buffer. Abort and start are
// registered one-cycle pulses. Assumes acq_vld and rel_vld are not both
// high; if they are, the acquire is taken and the release dropped.
module elision_ctrl #(
    parameter int MAX_NEST = 7,
    parameter int DEPTH    = 2,
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int IPW      = 48,
    parameter int CW       = elide_pkg::cnt_w(MAX_NEST)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_vld,
    input  logic             rel_vld,
    input  logic [AW-1:0]    lock_addr,
    input  logic [DW-1:0]    lock_data,
    input  logic [IPW-1:0]   cur_ip,
    input  logic             ext_abort,
    input  logic             commit_done,
    input  logic             commit_ok,
    output logic             commit_req,
    output logic             active,
    output logic [CW-1:0]    nest_level,
    output logic             tx_start,
    output logic             abort,
    output logic             discard,
    output logic [IPW-1:0]   restart_ip,
    output logic [DEPTH-1:0] buf_valid
);
    logic           active_q, pend_q, start_q, abort_q, discard_q;
    logic [IPW-1:0] rip_q;
    logic           at_max, lvl_zero, lvl_one;
    logic           free_avail, hit, val_ok, left_after;
    logic           acq_go, rel_go, abort_now;
    logic           do_inc, do_dec, do_alloc, do_free;
    logic           outer_acq, outer_rel, commit_pass;

    // Purpose: qualify events and decide whether this cycle aborts.
    always_comb begin
        acq_go      = acq_vld && !pend_q;
        rel_go      = rel_vld && !acq_vld && !pend_q && !lvl_zero;
        commit_pass = pend_q && commit_done && commit_ok;
        abort_now   = (ext_abort && active_q)
                    || (acq_go && at_max)
                    || (rel_go && hit && !val_ok)
                    || (rel_go && lvl_one && left_after)
                    || (pend_q && commit_done && !commit_ok);
        do_inc      = acq_go && !at_max && !abort_now;
        do_dec      = rel_go && !abort_now;
        do_alloc    = do_inc && free_avail;
        do_free     = do_dec && hit && val_ok;
        outer_acq   = do_inc && lvl_zero;
        outer_rel   = do_dec && lvl_one;
    end

    elide_nest_cnt #(.MAX_NEST(MAX_NEST), .CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (do_inc),
        .dec     (do_dec),
        .clr     (abort_now),
        .level   (nest_level),
        .at_max  (at_max),
        .is_zero (lvl_zero),
        .is_one  (lvl_one)
    );

    elide_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (abort_now),
        .alloc      (do_alloc),
        .rel_free   (do_free),
        .addr       (lock_addr),
        .data       (lock_data),
        .free_avail (free_avail),
        .hit        (hit),
        .val_ok     (val_ok),
        .left_after (left_after),
        .valid_o    (buf_valid)
    );

    // Purpose: track the active flag and the pending commit.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_now) begin
            active_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (outer_acq)        active_q <= 1'b1;
            else if (commit_pass) active_q <= 1'b0;
            if (outer_rel)        pend_q <= 1'b1;
            else if (pend_q && commit_done) pend_q <= 1'b0;
        end
    end

    // Purpose: capture the restart pointer on the outermost acquire.
    always_ff @(posedge clk) begin
        if (!rst_n)         rip_q <= '0;
        else if (outer_acq) rip_q <= cur_ip;
    end

    // Purpose: register the one-cycle start, abort and discard pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q   <= 1'b0;
            abort_q   <= 1'b0;
            discard_q <= 1'b0;
        end else begin
            start_q   <= outer_acq;
            abort_q   <= abort_now;
            discard_q <= abort_now;
        end
    end

    assign active     = active_q;
    assign commit_req = pend_q;
    assign tx_start   = start_q;
    assign abort      = abort_q;
    assign discard    = discard_q;
    assign restart_ip = rip_q;

    // R1
    start_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> tx_start);

    // R2
    max_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_vld && !pend_q && at_max) |=> abort);

    // R6
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_vld && !acq_vld && !active && !ext_abort) |=> (!active && !abort));

    // R7
    commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !commit_done && !ext_abort) |=> commit_req);

    // R10
    abort_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (!active && nest_level == '0 && buf_valid == '0 && !commit_req));

    // R10
    abort_keeps_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> $stable(restart_ip));

    // R11
    ext_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_abort && active) |=> abort);
endmodule

// File: tb/tb_elision_ctrl.sv
// Directed bench for the lock elision controller: one task per scenario.
module tb_elision_ctrl;
    localparam int MAX_NEST = 7;
    localparam int DEPTH    = 2;
    localparam int AW       = 32;
    localparam int DW       = 32;
    localparam int IPW      = 48;
    localparam int CW       = $clog2(MAX_NEST + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acq_vld = 1'b0, rel_vld = 1'b0;
    logic [AW-1:0]    lock_addr = '0;
    logic [DW-1:0]    lock_data = '0;
    logic [IPW-1:0]   cur_ip = '0;
    logic             ext_abort = 1'b0, commit_done = 1'b0, commit_ok = 1'b0;
    logic             commit_req, active, tx_start, abort, discard;
    logic [CW-1:0]    nest_level;
    logic [IPW-1:0]   restart_ip;
    logic [DEPTH-1:0] buf_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    elision_ctrl #(.MAX_NEST(MAX_NEST), .DEPTH(DEPTH), .AW(AW), .DW(DW), .IPW(IPW)) dut (
        .clk(clk), .rst_n(rst_n), .acq_vld(acq_vld), .rel_vld(rel_vld),
        .lock_addr(lock_addr), .lock_data(lock_data), .cur_ip(cur_ip),
        .ext_abort(ext_abort), .commit_done(commit_done), .commit_ok(commit_ok),
        .commit_req(commit_req), .active(active), .nest_level(nest_level),
        .tx_start(tx_start), .abort(abort), .discard(discard),
        .restart_ip(restart_ip), .buf_valid(buf_valid)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Drive one event for one cycle; outputs are sampled at the next negedge.
    task automatic ev_acq(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [IPW-1:0] ip);
        @(negedge clk);
        acq_vld = 1'b1; lock_addr = a; lock_data = d; cur_ip = ip;
        @(negedge clk);
        acq_vld = 1'b0;
    endtask

    task automatic ev_rel(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        rel_vld = 1'b1; lock_addr = a; lock_data = d;
        @(negedge clk);
        rel_vld = 1'b0;
    endtask

    task automatic ev_done(input logic ok);
        @(negedge clk);
        commit_done = 1'b1; commit_ok = ok;
        @(negedge clk);
        commit_done = 1'b0; commit_ok = 1'b0;
    endtask

    task automatic ev_ext;
        @(negedge clk);
        ext_abort = 1'b1;
        @(negedge clk);
        ext_abort = 1'b0;
    endtask

    task automatic t_reset;
        check("R10 reset active", 64'(active), 0);
        check("R10 reset level", 64'(nest_level), 0);
        check("R10 reset buf", 64'(buf_valid), 0);
        check("R7 reset commit_req", 64'(commit_req), 0);
        check("R10 reset abort", 64'(abort), 0);
    endtask

    task automatic t_simple_commit;
        ev_acq(32'hA0, 32'h11, 48'h100);
        check("R1 active set", 64'(active), 1);
        check("R1 level 1", 64'(nest_level), 1);
        check("R1 start pulse", 64'(tx_start), 1);
        check("R1 restart ip", 64'(restart_ip), 64'h100);
        check("R3 entry0 taken", 64'(buf_valid), 2'b01);
        ev_rel(32'hA0, 32'h11);
        check("R4 level 0", 64'(nest_level), 0);
        check("R4 entry freed", 64'(buf_valid), 0);
        check("R7 commit req", 64'(commit_req), 1);
        repeat (2) @(negedge clk);
        check("R7 commit held", 64'(commit_req), 1);
        ev_done(1'b1);
        check("R7 active clear", 64'(active), 0);
        check("R7 req clear", 64'(commit_req), 0);
        check("R7 no abort", 64'(abort), 0);
    endtask

    task automatic t_nested_fail;
        ev_acq(32'hB0, 32'h1, 48'h200);
        ev_acq(32'hB4, 32'h2, 48'h204);
        check("R1 inner keeps ip", 64'(restart_ip), 64'h200);
        check("R1 no start inner", 64'(tx_start), 0);
        check("R3 both taken", 64'(buf_valid), 2'b11);
        ev_acq(32'hB8, 32'h3, 48'h208);
        check("R3 full still nests", 64'(nest_level), 3);
        check("R3 full no alloc", 64'(buf_valid), 2'b11);
        ev_rel(32'hB8, 32'h3);
        check("R4 unmatched dec", 64'(nest_level), 2);
        check("R4 unmatched no abort", 64'(abort), 0);
        ev_rel(32'hB4, 32'h2);
        check("R4 entry1 freed", 64'(buf_valid), 2'b01);
        ev_rel(32'hB0, 32'h1);
        check("R7 outer commit", 64'(commit_req), 1);
        ev_done(1'b0);
        check("R8 fail abort", 64'(abort), 1);
        check("R10 discard", 64'(discard), 1);
        check("R10 active clear", 64'(active), 0);
        check("R10 ip kept", 64'(restart_ip), 64'h200);
        @(negedge clk);
        check("R10 pulse one cycle", 64'(abort), 0);
    endtask

    task automatic t_mismatch;
        ev_acq(32'hC0, 32'h5, 48'h300);
        ev_rel(32'hC0, 32'h6);
        check("R5 value abort", 64'(abort), 1);
        check("R5 buf cleared", 64'(buf_valid), 0);
        check("R5 level cleared", 64'(nest_level), 0);
    endtask

    task automatic t_leftover;
        ev_acq(32'hD0, 32'h7, 48'h400);
        ev_rel(32'hD8, 32'h7);
        check("R9 leftover abort", 64'(abort), 1);
        check("R9 no commit", 64'(commit_req), 0);
    endtask

    task automatic t_max;
        for (int i = 0; i < MAX_NEST; i++) ev_acq(32'hE00 + 32'(4 * i), 32'(i), 48'h500 + 48'(i));
        check("R1 at max", 64'(nest_level), MAX_NEST);
        check("R2 no abort yet", 64'(abort), 0);
        ev_acq(32'hEF0, 32'h9, 48'h600);
        check("R2 over max abort", 64'(abort), 1);
        check("R2 level zero", 64'(nest_level), 0);
        check("R2 ip is outer", 64'(restart_ip), 64'h500);
    endtask

    task automatic t_idle;
        ev_rel(32'hF0, 32'h1);
        check("R6 level", 64'(nest_level), 0);
        check("R6 active", 64'(active), 0);
        check("R6 no abort", 64'(abort), 0);
        check("R6 no commit", 64'(commit_req), 0);
        ev_ext;
        check("R11 idle ignored", 64'(abort), 0);
    endtask

    task automatic t_ext;
        ev_acq(32'h10, 32'h1, 48'h700);
        ev_acq(32'h14, 32'h2, 48'h704);
        ev_ext;
        check("R11 ext abort", 64'(abort), 1);
        check("R11 buf cleared", 64'(buf_valid), 0);
        check("R11 level cleared", 64'(nest_level), 0);
        check("R11 ip kept", 64'(restart_ip), 64'h700);
    endtask

    task automatic t_pending;
        ev_acq(32'h20, 32'h1, 48'h800);
        ev_rel(32'h20, 32'h1);
        check("R12 pending", 64'(commit_req), 1);
        ev_acq(32'h24, 32'h2, 48'h900);
        check("R12 acq ignored level", 64'(nest_level), 0);
        check("R12 acq ignored buf", 64'(buf_valid), 0);
        check("R12 ip unchanged", 64'(restart_ip), 64'h800);
        ev_done(1'b1);
        check("R12 commit ok", 64'(active), 0);
        check("R12 no abort", 64'(abort), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_simple_commit;
        t_nested_fail;
        t_mismatch;
        t_leftover;
        t_max;
        t_idle;
        t_ext;
        t_pending;
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule